// File: doc/BRIEF.md
# Suspendable Weighted Sum Accumulator

This block builds the two running sums behind a weighted average over a list held in byte-wide memory. A start command brings in three things: a base address for a list of 8-bit positions, a base address for a list of 8-bit weights, and an 8-bit entry count. The block then walks both lists together. For every entry it fetches one position and one weight. It adds their product to a 24-bit numerator and adds the weight to a 16-bit denominator. When the walk ends, the numerator is ready as a 32-bit dividend split into two 16-bit halves, and the denominator is ready as a 16-bit divisor for an unsigned divide that follows.

Each entry takes a fixed eight-cycle slot. A pending interrupt request is looked at once per slot, on its last cycle. If the request is accepted, the block parks in a suspended state. While parked it shows its partial sums, both pointers and the entries still to do, so that surrounding logic can save them. A later resume command loads a saved context and carries on without clearing the sums. A fresh start can run while another operation is parked, and the parked operation can be resumed afterwards.

Top module: `wavg_accum`

## Requirements
- R1: After reset the block is idle. busy, suspended, done and mem_req are all low, and num_sum and den_sum are zero.
- R2: A start with a count n from 1 to 255 clears both sums and loads both pointers and the count. On completion num_sum is the sum over i<n of pos[pos_base+i]*wgt[wgt_base+i], kept to 24 bits, and den_sum is the sum of the weights, kept to 16 bits. Addresses wrap at 16 bits.
- R3: Each entry takes exactly 8 cycles. With no interrupt, done is high in the cycle that follows the 8n-th rising edge after the edge that samples start.
- R4: Each entry makes exactly two reads. The position is read first at s_ptr, and the weight is read in the next cycle at f_ptr. Read data is taken one cycle after mem_req. Both pointers then advance by one.
- R5: A start with count 0 raises done on the first edge after it. Both sums are zero and no read is made.
- R6: An interrupt is sampled only on the last cycle of an entry, and only when entries remain. On acceptance, suspended goes high in the cycle after that edge. While suspended, mem_req stays low and num_sum, den_sum, s_ptr, f_ptr and left stay unchanged until a start or a resume.
- R7: On the final entry, completion takes priority over a pending interrupt. A request held high for a whole run of n entries therefore gives exactly n-1 suspensions and then done.
- R8: A resume loads num_sum, den_sum, s_ptr, f_ptr and left from the ctx inputs without clearing them, and continues from there. The final sums match an uninterrupted run however many times the operation is suspended. A resume with ctx_left of 0 raises done on the next edge and makes no reads.
- R9: A start is accepted while another operation is suspended, and the suspended operation can later be resumed from its saved context. When start and resume are sampled on the same edge, start wins.
- R10: div_hi is num_sum zero-extended to 32 bits, upper half. div_lo is the lower 16 bits of num_sum. divisor equals den_sum.
- R11: done is a one-cycle pulse and is never high together with suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Fresh start command, one-cycle pulse |
| resume | input | 1 | Resume command, loads the ctx inputs |
| count | input | 8 | Number of entries for a fresh start |
| pos_base | input | 16 | Address of the first position byte |
| wgt_base | input | 16 | Address of the first weight byte |
| ctx_num | input | 24 | Saved numerator for resume |
| ctx_den | input | 16 | Saved denominator for resume |
| ctx_s_ptr | input | 16 | Saved position pointer for resume |
| ctx_f_ptr | input | 16 | Saved weight pointer for resume |
| ctx_left | input | 8 | Saved count of remaining entries for resume |
| irq_pend | input | 1 | Pending interrupt request |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_req |
| busy | output | 1 | An entry walk is in progress |
| suspended | output | 1 | Parked by an accepted interrupt |
| done | output | 1 | One-cycle completion pulse |
| num_sum | output | 24 | Numerator partial or final sum |
| den_sum | output | 16 | Denominator partial or final sum |
| s_ptr | output | 16 | Next position address |
| f_ptr | output | 16 | Next weight address |
| left | output | 8 | Entries still to process |
| div_hi | output | 16 | Upper half of the dividend |
| div_lo | output | 16 | Lower half of the dividend |
| divisor | output | 16 | Divisor for the following divide |

## Verification
Two events can fall on the same edge: completion of the last entry and acceptance of a pending interrupt. The bench provokes this by holding irq_pend high for a whole run of 40 entries and again for 255 entries. It judges the outcome by counting exactly n-1 suspensions, followed by a done pulse whose operands match the model. Start and resume are also driven on the same edge. The bench checks that the fresh operation's reads and sums win, and that the garbage context is ignored.

// File: rtl/wavg_pkg.sv
package wavg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } run_st_e;

    localparam int LOOP_CYCLES = 8;
    localparam int PHW         = $clog2(LOOP_CYCLES);

    typedef logic [PHW-1:0] phase_t;

    // slot schedule of one entry
    localparam phase_t PH_RD_POS  = phase_t'(0);
    localparam phase_t PH_RD_WGT  = phase_t'(1);
    localparam phase_t PH_CAP_WGT = phase_t'(2);
    localparam phase_t PH_MUL     = phase_t'(3);
    localparam phase_t PH_ADD_NUM = phase_t'(4);
    localparam phase_t PH_ADD_DEN = phase_t'(5);
    localparam phase_t PH_STEP    = phase_t'(6);
    localparam phase_t PH_LAST    = phase_t'(LOOP_CYCLES - 1);

    typedef struct packed {
        logic rd_pos;
        logic rd_wgt;
        logic cap_pos;
        logic cap_wgt;
        logic mul;
        logic add_num;
        logic add_den;
        logic step;
    } ctl_t;

    function automatic ctl_t decode_phase(input run_st_e st, input phase_t ph);
        ctl_t c;
        c = '0;
        if (st == ST_RUN) begin
            c.rd_pos  = (ph == PH_RD_POS);
            c.rd_wgt  = (ph == PH_RD_WGT);
            c.cap_pos = (ph == PH_RD_WGT);
            c.cap_wgt = (ph == PH_CAP_WGT);
            c.mul     = (ph == PH_MUL);
            c.add_num = (ph == PH_ADD_NUM);
            c.add_den = (ph == PH_ADD_DEN);
            c.step    = (ph == PH_STEP);
        end
        return c;
    endfunction

endpackage

// File: rtl/wavg_seq.sv
module wavg_seq
    import wavg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          resume,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] ctx_left,
    input  logic          left_zero,
    input  logic          irq_pend,
    output run_st_e       st,
    output ctl_t          ctl,
    output logic          done,
    output logic          ld_fresh,
    output logic          ld_resume
);

    phase_t ph;

    assign ld_fresh  = start;
    assign ld_resume = resume & ~start;
    assign ctl       = decode_phase(st, ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ph   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                ph <= '0;
                if (count == '0) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end else begin
                    st <= ST_RUN;
                end
            end else if (resume) begin
                ph <= '0;
                if (ctx_left == '0) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end else begin
                    st <= ST_RUN;
                end
            end else if (st == ST_RUN) begin
                if (ph == PH_LAST) begin
                    ph <= '0;
                    if (left_zero) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else if (irq_pend) begin
                        st <= ST_SUSP;
                    end
                end else begin
                    ph <= ph + phase_t'(1);
                end
            end
        end
    end

    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && ph != PH_LAST && !start && !resume) |=> (st == ST_RUN)); // R6
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP && !start && !resume) |=> (st == ST_SUSP && !done)); // R6
    AST_LAST_WINS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && ph == PH_LAST && left_zero && !start && !resume)
        |=> (done && st == ST_IDLE)); // R7
    AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
        (start && resume && count != '0) |=> (st == ST_RUN && ph == '0)); // R9

endmodule

// File: rtl/wavg_dp.sv
module wavg_dp
    import wavg_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int DW  = 8,
    parameter int NW  = 24,
    parameter int DNW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  ctl_t           ctl,
    input  logic           ld_fresh,
    input  logic           ld_resume,
    input  logic [AW-1:0]  pos_base,
    input  logic [AW-1:0]  wgt_base,
    input  logic [CW-1:0]  count,
    input  logic [NW-1:0]  ctx_num,
    input  logic [DNW-1:0] ctx_den,
    input  logic [AW-1:0]  ctx_s_ptr,
    input  logic [AW-1:0]  ctx_f_ptr,
    input  logic [CW-1:0]  ctx_left,
    input  logic [DW-1:0]  mem_rdata,
    output logic [NW-1:0]  num,
    output logic [DNW-1:0] den,
    output logic [AW-1:0]  s_ptr,
    output logic [AW-1:0]  f_ptr,
    output logic [CW-1:0]  left,
    output logic           left_zero
);

    localparam int PW = 2 * DW;

    logic [DW-1:0] pos_q;
    logic [DW-1:0] wgt_q;
    logic [PW-1:0] prod_q;

    assign left_zero = (left == '0);

    // operand capture and product stage
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            wgt_q  <= '0;
            prod_q <= '0;
        end else begin
            if (ctl.cap_pos) pos_q  <= mem_rdata;
            if (ctl.cap_wgt) wgt_q  <= mem_rdata;
            if (ctl.mul)     prod_q <= PW'(pos_q) * PW'(wgt_q);
        end
    end

    // sums, pointers and remaining count
    always_ff @(posedge clk) begin
        if (rst) begin
            num   <= '0;
            den   <= '0;
            s_ptr <= '0;
            f_ptr <= '0;
            left  <= '0;
        end else if (ld_fresh) begin
            num   <= '0;
            den   <= '0;
            s_ptr <= pos_base;
            f_ptr <= wgt_base;
            left  <= count;
        end else if (ld_resume) begin
            num   <= ctx_num;
            den   <= ctx_den;
            s_ptr <= ctx_s_ptr;
            f_ptr <= ctx_f_ptr;
            left  <= ctx_left;
        end else begin
            if (ctl.add_num) num <= num + NW'(prod_q);
            if (ctl.add_den) den <= den + DNW'(wgt_q);
            if (ctl.step) begin
                s_ptr <= s_ptr + AW'(1);
                f_ptr <= f_ptr + AW'(1);
                left  <= left - CW'(1);
            end
        end
    end

    AST_FRESH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ld_fresh |=> (num == '0 && den == '0)); // R2
    AST_RESUME_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_resume |=> (num == $past(ctx_num) && den == $past(ctx_den) && left == $past(ctx_left))); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (left != '0)); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ld_fresh && !ld_resume) |=> (s_ptr == $past(s_ptr) + AW'(1))); // R4

endmodule

// File: rtl/wavg_accum.sv
module wavg_accum
    import wavg_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int DW  = 8,
    parameter int NW  = 24,
    parameter int DNW = 16,
    parameter int QW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           resume,
    input  logic [CW-1:0]  count,
    input  logic [AW-1:0]  pos_base,
    input  logic [AW-1:0]  wgt_base,
    input  logic [NW-1:0]  ctx_num,
    input  logic [DNW-1:0] ctx_den,
    input  logic [AW-1:0]  ctx_s_ptr,
    input  logic [AW-1:0]  ctx_f_ptr,
    input  logic [CW-1:0]  ctx_left,
    input  logic           irq_pend,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           busy,
    output logic           suspended,
    output logic           done,
    output logic [NW-1:0]  num_sum,
    output logic [DNW-1:0] den_sum,
    output logic [AW-1:0]  s_ptr,
    output logic [AW-1:0]  f_ptr,
    output logic [CW-1:0]  left,
    output logic [QW-1:0]  div_hi,
    output logic [QW-1:0]  div_lo,
    output logic [QW-1:0]  divisor
);

    localparam int DVW = 2 * QW;

    run_st_e        st;
    ctl_t           ctl;
    logic           ld_fresh;
    logic           ld_resume;
    logic           left_zero;
    logic [DVW-1:0] dividend;

    wavg_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .resume    (resume),
        .count     (count),
        .ctx_left  (ctx_left),
        .left_zero (left_zero),
        .irq_pend  (irq_pend),
        .st        (st),
        .ctl       (ctl),
        .done      (done),
        .ld_fresh  (ld_fresh),
        .ld_resume (ld_resume)
    );

    wavg_dp #(.AW(AW), .CW(CW), .DW(DW), .NW(NW), .DNW(DNW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .ld_fresh  (ld_fresh),
        .ld_resume (ld_resume),
        .pos_base  (pos_base),
        .wgt_base  (wgt_base),
        .count     (count),
        .ctx_num   (ctx_num),
        .ctx_den   (ctx_den),
        .ctx_s_ptr (ctx_s_ptr),
        .ctx_f_ptr (ctx_f_ptr),
        .ctx_left  (ctx_left),
        .mem_rdata (mem_rdata),
        .num       (num_sum),
        .den       (den_sum),
        .s_ptr     (s_ptr),
        .f_ptr     (f_ptr),
        .left      (left),
        .left_zero (left_zero)
    );

    assign mem_req   = ctl.rd_pos | ctl.rd_wgt;
    assign mem_addr  = ctl.rd_pos ? s_ptr : f_ptr;
    assign busy      = (st == ST_RUN);
    assign suspended = (st == ST_SUSP);

    // divide operand hand-off
    assign dividend = DVW'(num_sum);
    assign div_hi   = dividend[DVW-1:QW];
    assign div_lo   = dividend[QW-1:0];
    assign divisor  = QW'(den_sum);

    AST_DONE_NOT_SUSP: assert property (@(posedge clk) disable iff (rst)
        done |-> !suspended); // R11
    AST_QUIET_PARKED: assert property (@(posedge clk) disable iff (rst)
        suspended |-> !mem_req); // R6
    AST_PARKED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (suspended && !start && !resume) |=> ($stable(num_sum) && $stable(den_sum))); // R6

endmodule

// File: tb/wavg_accum_test.sv
module wavg_accum_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [23:0] num;
        logic [15:0] den;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        resume = 1'b0;
    logic [7:0]  count = '0;
    logic [15:0] pos_base = '0;
    logic [15:0] wgt_base = '0;
    logic [23:0] ctx_num = '0;
    logic [15:0] ctx_den = '0;
    logic [15:0] ctx_s_ptr = '0;
    logic [15:0] ctx_f_ptr = '0;
    logic [7:0]  ctx_left = '0;
    logic        irq_pend = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        busy, suspended, done;
    logic [23:0] num_sum;
    logic [15:0] den_sum;
    logic [15:0] s_ptr, f_ptr;
    logic [7:0]  left;
    logic [15:0] div_hi, div_lo, divisor;

    int n_chk = 0;
    int n_fail = 0;
    exp_t sb_q[$];

    int          reads = 0;
    int          rd_err = 0;
    bit          rd_par = 1'b0;
    logic [15:0] exp_s = '0;
    logic [15:0] exp_f = '0;
    bit          prev_done = 1'b0;

    wavg_accum uut (
        .clk(clk), .rst(rst), .start(start), .resume(resume), .count(count),
        .pos_base(pos_base), .wgt_base(wgt_base), .ctx_num(ctx_num), .ctx_den(ctx_den),
        .ctx_s_ptr(ctx_s_ptr), .ctx_f_ptr(ctx_f_ptr), .ctx_left(ctx_left),
        .irq_pend(irq_pend), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .suspended(suspended), .done(done), .num_sum(num_sum),
        .den_sum(den_sum), .s_ptr(s_ptr), .f_ptr(f_ptr), .left(left),
        .div_hi(div_hi), .div_lo(div_lo), .divisor(divisor)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd29 + (a >> 5);
        return t[7:0] ^ t[15:8];
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) mem_rdata <= mem_byte(mem_addr);

    function automatic exp_t model(input int n, input logic [15:0] sb, input logic [15:0] fb,
                                   input logic [23:0] n0, input logic [15:0] d0);
        exp_t e;
        e.num = n0;
        e.den = d0;
        for (int i = 0; i < n; i++) begin
            e.num = e.num + 24'(mem_byte(sb + 16'(i)) * mem_byte(fb + 16'(i)));
            e.den = e.den + 16'(mem_byte(fb + 16'(i)));
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // read monitor (R4)
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            reads++;
            if (!rd_par) begin
                if (mem_addr != exp_s) rd_err++;
                exp_s = exp_s + 16'd1;
            end else begin
                if (mem_addr != exp_f) rd_err++;
                exp_f = exp_f + 16'd1;
            end
            rd_par = ~rd_par;
        end
    end

    // result monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) chk(!done, "R11", "done longer than one cycle", 64'(done), 64'd0);
            if (done) begin
                chk(!suspended, "R11", "done with suspended", 64'(suspended), 64'd0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(num_sum == e.num, "R2", "numerator", 64'(num_sum), 64'(e.num));
                    chk(divisor == e.den, "R2", "denominator", 64'(divisor), 64'(e.den));
                    chk({div_hi, div_lo} == {8'd0, e.num}, "R10", "dividend halves",
                        64'({div_hi, div_lo}), 64'(e.num));
                end
            end
            prev_done = done;
        end
    end

    task automatic pulse_start(input int n, input logic [15:0] sb, input logic [15:0] fb);
        count = 8'(n);
        pos_base = sb;
        wgt_base = fb;
        exp_s = sb;
        exp_f = fb;
        rd_par = 1'b0;
        reads = 0;
        rd_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_evt(output int cyc);
        cyc = 1;
        while (!done && !suspended && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // called while suspended: check it is parked, then resume from the exposed context
    task automatic park_and_resume();
        logic [23:0] sn;
        logic [15:0] sd, sp, fp;
        logic [7:0]  sl;
        bit          quiet;
        sn = num_sum; sd = den_sum; sp = s_ptr; fp = f_ptr; sl = left;
        quiet = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (mem_req || !suspended) quiet = 1'b0;
        end
        chk(quiet && num_sum == sn && den_sum == sd && s_ptr == sp && f_ptr == fp && left == sl,
            "R6", "parked state not held", 64'({num_sum, den_sum}), 64'({sn, sd}));
        ctx_num = sn; ctx_den = sd; ctx_s_ptr = sp; ctx_f_ptr = fp; ctx_left = sl;
        exp_s = sp;
        exp_f = fp;
        rd_par = 1'b0;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
    endtask

    task automatic run_op(input int n, input logic [15:0] sb, input logic [15:0] fb,
                          input bit hold_irq, output int susp, output int first_cyc);
        int cyc;
        bit first;
        sb_q.push_back(model(n, sb, fb, 24'd0, 16'd0));
        irq_pend = hold_irq;
        susp = 0;
        first = 1'b1;
        first_cyc = 0;
        pulse_start(n, sb, fb);
        forever begin
            wait_evt(cyc);
            if (first) first_cyc = cyc;
            first = 1'b0;
            if (done || cyc >= 20000) break;
            susp++;
            park_and_resume();
        end
        irq_pend = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        int susp, cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !suspended && !done && !mem_req, "R1", "control after reset",
            64'({busy, suspended, done, mem_req}), 64'd0);
        chk(num_sum == 0 && den_sum == 0, "R1", "sums after reset",
            64'({num_sum, den_sum}), 64'd0);

        // R2 R3 R4: plain runs of several lengths
        run_op(1, 16'h0040, 16'h0300, 1'b0, susp, cyc);
        chk(cyc == 9, "R3", "latency n=1", 64'(cyc), 64'd9);
        chk(reads == 2 && rd_err == 0, "R4", "reads n=1", 64'(reads), 64'd2);

        run_op(8, 16'h1000, 16'h2000, 1'b0, susp, cyc);
        chk(cyc == 65, "R3", "latency n=8", 64'(cyc), 64'd65);
        chk(reads == 16 && rd_err == 0, "R4", "reads n=8", 64'(reads), 64'd16);

        run_op(255, 16'hFF80, 16'h7F00, 1'b0, susp, cyc);
        chk(cyc == 2041, "R3", "latency n=255", 64'(cyc), 64'd2041);
        chk(reads == 510 && rd_err == 0, "R4", "reads n=255", 64'(reads), 64'd510);

        // R5 zero count
        run_op(0, 16'h0500, 16'h0600, 1'b0, susp, cyc);
        chk(cyc == 1, "R5", "latency n=0", 64'(cyc), 64'd1);
        chk(reads == 0, "R5", "reads n=0", 64'(reads), 64'd0);

        // R6 single interrupt at the first boundary
        begin
            exp_t part;
            sb_q.push_back(model(5, 16'h0A00, 16'h0B00, 24'd0, 16'd0));
            part = model(1, 16'h0A00, 16'h0B00, 24'd0, 16'd0);
            irq_pend = 1'b1;
            pulse_start(5, 16'h0A00, 16'h0B00);
            wait_evt(cyc);
            chk(suspended && cyc == 9, "R6", "suspend cycle", 64'(cyc), 64'd9);
            chk(left == 4 && s_ptr == 16'h0A01 && f_ptr == 16'h0B01, "R6", "exposed pointers",
                64'({left, s_ptr, f_ptr}), 64'({8'd4, 16'h0A01, 16'h0B01}));
            chk(num_sum == part.num && den_sum == part.den, "R6", "exposed partial sums",
                64'({num_sum, den_sum}), 64'(part));
            irq_pend = 1'b0;
            park_and_resume();
            wait_evt(cyc);
            chk(done, "R8", "done after resume", 64'(done), 64'd1);
            chk(reads == 10 && rd_err == 0, "R8", "reads across resume", 64'(reads), 64'd10);
            @(negedge clk);
        end

        // R7 interrupt held the whole run
        run_op(40, 16'h3000, 16'h3100, 1'b1, susp, cyc);
        chk(susp == 39, "R7", "suspensions n=40", 64'(susp), 64'd39);
        chk(reads == 80 && rd_err == 0, "R8", "reads n=40 interrupted", 64'(reads), 64'd80);
        run_op(255, 16'h4400, 16'h5500, 1'b1, susp, cyc);
        chk(susp == 254, "R7", "suspensions n=255", 64'(susp), 64'd254);

        // R9 fresh run while another is parked
        begin
            logic [23:0] an;
            logic [15:0] ad, asp, afp;
            logic [7:0]  al;
            irq_pend = 1'b1;
            pulse_start(10, 16'h6000, 16'h6100);
            repeat (3) begin
                wait_evt(cyc);
                if (suspended) begin
                    irq_pend = 1'b1;
                    park_and_resume();
                end
            end
            wait_evt(cyc);
            chk(suspended, "R9", "outer parked", 64'(suspended), 64'd1);
            an = num_sum; ad = den_sum; asp = s_ptr; afp = f_ptr; al = left;
            irq_pend = 1'b0;
            run_op(3, 16'h7000, 16'h7100, 1'b0, susp, cyc);
            chk(reads == 6 && rd_err == 0, "R9", "nested reads", 64'(reads), 64'd6);
            sb_q.push_back(model(10, 16'h6000, 16'h6100, 24'd0, 16'd0));
            ctx_num = an; ctx_den = ad; ctx_s_ptr = asp; ctx_f_ptr = afp; ctx_left = al;
            exp_s = asp; exp_f = afp; rd_par = 1'b0; reads = 0; rd_err = 0;
            resume = 1'b1;
            @(negedge clk);
            resume = 1'b0;
            wait_evt(cyc);
            chk(done && rd_err == 0 && reads == 2 * int'(al), "R9", "outer resumed",
                64'(reads), 64'(2 * int'(al)));
            @(negedge clk);
        end

        // R9 start and resume on the same edge: start wins
        ctx_num = 24'hABCDEF; ctx_den = 16'h1234; ctx_s_ptr = 16'h9999;
        ctx_f_ptr = 16'h8888; ctx_left = 8'd7;
        sb_q.push_back(model(4, 16'h0C00, 16'h0D00, 24'd0, 16'd0));
        resume = 1'b1;
        pulse_start(4, 16'h0C00, 16'h0D00);
        resume = 1'b0;
        wait_evt(cyc);
        chk(cyc == 33 && reads == 8 && rd_err == 0, "R9", "start beats resume",
            64'({cyc, reads}), 64'({32'd33, 32'd8}));
        @(negedge clk);

        // R8 resume with nothing left
        ctx_num = 24'h123456; ctx_den = 16'hBEEF; ctx_left = 8'd0;
        sb_q.push_back('{num: 24'h123456, den: 16'hBEEF});
        reads = 0;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        wait_evt(cyc);
        chk(cyc == 1 && reads == 0, "R8", "empty resume", 64'({cyc, reads}), 64'({32'd1, 32'd0}));
        @(negedge clk);

        // R8 resume from idle keeps the loaded sums
        ctx_num = 24'd1000; ctx_den = 16'd50; ctx_s_ptr = 16'h2200;
        ctx_f_ptr = 16'h2300; ctx_left = 8'd3;
        sb_q.push_back(model(3, 16'h2200, 16'h2300, 24'd1000, 16'd50));
        exp_s = 16'h2200; exp_f = 16'h2300; rd_par = 1'b0; reads = 0; rd_err = 0;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        wait_evt(cyc);
        chk(cyc == 25 && reads == 6 && rd_err == 0, "R8", "resume keeps sums",
            64'({cyc, reads}), 64'({32'd25, 32'd6}));
        repeat (2) @(negedge clk);

        chk(sb_q.size() == 0, "R2", "results outstanding", 64'(sb_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule